// File: doc/BRIEF.md
# Masked Time-of-Day Match Trigger

This block watches a running time-of-day value and raises a one-cycle trigger when the time reaches a programmed target. The target is written as separate fields. Each field has its own mask bit, so software can ask for a match on, for example, "every second at microsecond 500" or "day 123 at any time". The trigger output is meant to start an event sequencer.

Two time formats are supported, and a small source code chooses between them. The BCD format holds day of year, hour, minute and second as packed decimal digits, plus a binary microsecond count. The straight-binary format holds year, day of year and seconds of the day as plain binary numbers, plus the same microsecond count. Any other source code turns the block off.

The trigger is edge-based. It fires once when the comparison becomes true and stays quiet while the match persists. Reprogramming the target, the mask or the source code arms the block again, so a new setting can fire even when the time already matches it.

Top module: `tod_match_trigger`

## Requirements
- R1: Source code 2 selects BCD mode. In this mode the compared fields are: day of year (three BCD digits), hour, minute and second (two BCD digits each), and the microsecond count (binary).
- R2: Source code 3 selects binary mode. In this mode the compared fields are: year, day of year, seconds of the day and the microsecond count, all binary.
- R3: Any source code other than 2 or 3 never produces a trigger.
- R4: Each mask bit, when set, removes one field from the comparison. The bit positions are: bit 0 microseconds, bit 1 seconds, bit 2 minutes, bit 3 hours, bit 4 day, bit 5 year.
- R5: Some inputs have no effect depending on the mode:
  - In BCD mode, the year inputs and mask bit 5 are ignored.
  - In binary mode, the BCD inputs and mask bits 2 and 3 are ignored.
  - In binary mode, the seconds-of-day field is governed by mask bit 1.
- R6: If every field used by the selected mode is masked, no trigger is produced.
- R7: When the full comparison becomes true in a cycle, `trig_o` is high for exactly one cycle, starting one clock edge later. A later fall and rise of the match fires again.
- R8: While the match stays true and the targets, mask and source code are unchanged, no further trigger is produced.
- R9: A change to any target field, the mask or the source code re-arms the detector. If the new setting matches in the cycle of the change, a trigger follows one edge later.
- R10: While reset is asserted, `trig_o` is low. After reset is released, the first matching cycle produces exactly one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_code | input | 4 | Time source selector (2 BCD, 3 binary, other off) |
| fld_mask | input | 6 | Per-field exclude bits |
| cur_bcd_day | input | 12 | Current day of year, BCD |
| cur_bcd_hour | input | 8 | Current hour, BCD |
| cur_bcd_min | input | 8 | Current minute, BCD |
| cur_bcd_sec | input | 8 | Current second, BCD |
| cur_sb_year | input | 12 | Current year, binary |
| cur_sb_day | input | 9 | Current day of year, binary |
| cur_sb_sod | input | 17 | Current seconds of day, binary |
| cur_usec | input | 20 | Current microseconds, binary |
| tgt_bcd_day | input | 12 | Target day of year, BCD |
| tgt_bcd_hour | input | 8 | Target hour, BCD |
| tgt_bcd_min | input | 8 | Target minute, BCD |
| tgt_bcd_sec | input | 8 | Target second, BCD |
| tgt_sb_year | input | 12 | Target year, binary |
| tgt_sb_day | input | 9 | Target day of year, binary |
| tgt_sb_sod | input | 17 | Target seconds of day, binary |
| tgt_usec | input | 20 | Target microseconds, binary |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The comparison is combinational and feeds one register stage, so a trigger is due at the first clock edge after the matching inputs are presented. The bench drives inputs 1 ns after an edge and reads `trig_o` 1 ns after the next edge. One check samples before that edge, to confirm the pulse does not arrive early. Each table vector is preceded by idle cycles with the block off, so every vector starts with the detector armed. For reset, the bench counts pulses over a window instead of naming a cycle, because the reset release passes through a two-stage synchronizer.

// File: rtl/tod_match_pkg.sv
package tod_match_pkg;

  localparam int unsigned CODE_BCD = 2;
  localparam int unsigned CODE_SB  = 3;

  localparam int unsigned MASK_W  = 6;
  localparam int unsigned MB_USEC = 0;
  localparam int unsigned MB_SEC  = 1;
  localparam int unsigned MB_MIN  = 2;
  localparam int unsigned MB_HOUR = 3;
  localparam int unsigned MB_DAY  = 4;
  localparam int unsigned MB_YEAR = 5;

  // compare lanes
  localparam int unsigned NFLD   = 8;
  localparam int unsigned F_BDAY = 0;
  localparam int unsigned F_HOUR = 1;
  localparam int unsigned F_MIN  = 2;
  localparam int unsigned F_BSEC = 3;
  localparam int unsigned F_YEAR = 4;
  localparam int unsigned F_SDAY = 5;
  localparam int unsigned F_SOD  = 6;
  localparam int unsigned F_USEC = 7;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_BCD = 2'd1,
    MODE_SB  = 2'd2
  } tod_mode_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tod_mode_dec.sv
module tod_mode_dec
  import tod_match_pkg::*;
#(
  parameter int unsigned SRC_W = 4
) (
  input  logic [SRC_W-1:0] src_code_i,
  output tod_mode_e        mode_o
);

  always_comb begin
    if (src_code_i == SRC_W'(CODE_BCD)) begin
      mode_o = MODE_BCD;
    end else if (src_code_i == SRC_W'(CODE_SB)) begin
      mode_o = MODE_SB;
    end else begin
      mode_o = MODE_OFF;
    end
  end

endmodule

// File: rtl/tod_field_cmp.sv
module tod_field_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);

  assign eq_o = (a_i == b_i);

endmodule

// File: rtl/tod_match_core.sv
module tod_match_core
  import tod_match_pkg::*;
#(
  parameter int unsigned YEAR_W = 12,
  parameter int unsigned DAY_W  = 9,
  parameter int unsigned SOD_W  = 17,
  parameter int unsigned USEC_W = 20
) (
  input  tod_mode_e         mode_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [11:0]       cur_bcd_day_i,
  input  logic [7:0]        cur_bcd_hour_i,
  input  logic [7:0]        cur_bcd_min_i,
  input  logic [7:0]        cur_bcd_sec_i,
  input  logic [YEAR_W-1:0] cur_sb_year_i,
  input  logic [DAY_W-1:0]  cur_sb_day_i,
  input  logic [SOD_W-1:0]  cur_sb_sod_i,
  input  logic [USEC_W-1:0] cur_usec_i,
  input  logic [11:0]       tgt_bcd_day_i,
  input  logic [7:0]        tgt_bcd_hour_i,
  input  logic [7:0]        tgt_bcd_min_i,
  input  logic [7:0]        tgt_bcd_sec_i,
  input  logic [YEAR_W-1:0] tgt_sb_year_i,
  input  logic [DAY_W-1:0]  tgt_sb_day_i,
  input  logic [SOD_W-1:0]  tgt_sb_sod_i,
  input  logic [USEC_W-1:0] tgt_usec_i,
  output logic              match_o
);

  localparam int unsigned FW = max2(max2(max2(12, YEAR_W), max2(DAY_W, SOD_W)), USEC_W);

  logic [FW-1:0]   cur_f [NFLD];
  logic [FW-1:0]   tgt_f [NFLD];
  logic [NFLD-1:0] eq;

  assign cur_f[F_BDAY] = FW'(cur_bcd_day_i);
  assign cur_f[F_HOUR] = FW'(cur_bcd_hour_i);
  assign cur_f[F_MIN]  = FW'(cur_bcd_min_i);
  assign cur_f[F_BSEC] = FW'(cur_bcd_sec_i);
  assign cur_f[F_YEAR] = FW'(cur_sb_year_i);
  assign cur_f[F_SDAY] = FW'(cur_sb_day_i);
  assign cur_f[F_SOD]  = FW'(cur_sb_sod_i);
  assign cur_f[F_USEC] = FW'(cur_usec_i);

  assign tgt_f[F_BDAY] = FW'(tgt_bcd_day_i);
  assign tgt_f[F_HOUR] = FW'(tgt_bcd_hour_i);
  assign tgt_f[F_MIN]  = FW'(tgt_bcd_min_i);
  assign tgt_f[F_BSEC] = FW'(tgt_bcd_sec_i);
  assign tgt_f[F_YEAR] = FW'(tgt_sb_year_i);
  assign tgt_f[F_SDAY] = FW'(tgt_sb_day_i);
  assign tgt_f[F_SOD]  = FW'(tgt_sb_sod_i);
  assign tgt_f[F_USEC] = FW'(tgt_usec_i);

  for (genvar i = 0; i < NFLD; i++) begin : g_lane
    tod_field_cmp #(.W(FW)) u_cmp (
      .a_i  (cur_f[i]),
      .b_i  (tgt_f[i]),
      .eq_o (eq[i])
    );
  end

  logic bcd_ok, bcd_any, sb_ok, sb_any;

  always_comb begin
    bcd_ok  = (mask_i[MB_DAY]  | eq[F_BDAY]) &
              (mask_i[MB_HOUR] | eq[F_HOUR]) &
              (mask_i[MB_MIN]  | eq[F_MIN])  &
              (mask_i[MB_SEC]  | eq[F_BSEC]) &
              (mask_i[MB_USEC] | eq[F_USEC]);
    bcd_any = ~(mask_i[MB_DAY] & mask_i[MB_HOUR] & mask_i[MB_MIN] &
                mask_i[MB_SEC] & mask_i[MB_USEC]);
    sb_ok   = (mask_i[MB_YEAR] | eq[F_YEAR]) &
              (mask_i[MB_DAY]  | eq[F_SDAY]) &
              (mask_i[MB_SEC]  | eq[F_SOD])  &
              (mask_i[MB_USEC] | eq[F_USEC]);
    sb_any  = ~(mask_i[MB_YEAR] & mask_i[MB_DAY] & mask_i[MB_SEC] & mask_i[MB_USEC]);
    unique case (mode_i)
      MODE_BCD: match_o = bcd_ok & bcd_any;
      MODE_SB:  match_o = sb_ok & sb_any;
      default:  match_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tod_edge_arm.sv
module tod_edge_arm #(
  parameter int unsigned SETUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               match_i,
  input  logic [SETUP_W-1:0] setup_i,
  output logic               trig_o
);

  logic [SETUP_W-1:0] setup_q;
  logic               prev_q;
  logic               trig_q;
  logic               chg;
  logic               trig_d;

  always_comb begin
    chg    = (setup_i != setup_q);
    trig_d = match_i & (~prev_q | chg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      prev_q  <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      setup_q <= setup_i;
      prev_q  <= match_i;
      trig_q  <= trig_d;
    end
  end

  assign trig_o = trig_q;

endmodule

// File: rtl/tod_match_trigger.sv
module tod_match_trigger
  import tod_match_pkg::*;
#(
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned YEAR_W = 12,
  parameter int unsigned DAY_W  = 9,
  parameter int unsigned SOD_W  = 17,
  parameter int unsigned USEC_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_code,
  input  logic [5:0]        fld_mask,
  input  logic [11:0]       cur_bcd_day,
  input  logic [7:0]        cur_bcd_hour,
  input  logic [7:0]        cur_bcd_min,
  input  logic [7:0]        cur_bcd_sec,
  input  logic [YEAR_W-1:0] cur_sb_year,
  input  logic [DAY_W-1:0]  cur_sb_day,
  input  logic [SOD_W-1:0]  cur_sb_sod,
  input  logic [USEC_W-1:0] cur_usec,
  input  logic [11:0]       tgt_bcd_day,
  input  logic [7:0]        tgt_bcd_hour,
  input  logic [7:0]        tgt_bcd_min,
  input  logic [7:0]        tgt_bcd_sec,
  input  logic [YEAR_W-1:0] tgt_sb_year,
  input  logic [DAY_W-1:0]  tgt_sb_day,
  input  logic [SOD_W-1:0]  tgt_sb_sod,
  input  logic [USEC_W-1:0] tgt_usec,
  output logic              trig_o
);

  localparam int unsigned SETUP_W = SRC_W + MASK_W + 36 + YEAR_W + DAY_W + SOD_W + USEC_W;

  // reset: asserted at once, released on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  tod_mode_e          mode_w;
  logic               match_w;
  logic [SETUP_W-1:0] setup_w;

  assign setup_w = {src_code, fld_mask, tgt_bcd_day, tgt_bcd_hour, tgt_bcd_min,
                    tgt_bcd_sec, tgt_sb_year, tgt_sb_day, tgt_sb_sod, tgt_usec};

  tod_mode_dec #(.SRC_W(SRC_W)) u_dec (
    .src_code_i (src_code),
    .mode_o     (mode_w)
  );

  tod_match_core #(
    .YEAR_W (YEAR_W),
    .DAY_W  (DAY_W),
    .SOD_W  (SOD_W),
    .USEC_W (USEC_W)
  ) u_core (
    .mode_i         (mode_w),
    .mask_i         (fld_mask),
    .cur_bcd_day_i  (cur_bcd_day),
    .cur_bcd_hour_i (cur_bcd_hour),
    .cur_bcd_min_i  (cur_bcd_min),
    .cur_bcd_sec_i  (cur_bcd_sec),
    .cur_sb_year_i  (cur_sb_year),
    .cur_sb_day_i   (cur_sb_day),
    .cur_sb_sod_i   (cur_sb_sod),
    .cur_usec_i     (cur_usec),
    .tgt_bcd_day_i  (tgt_bcd_day),
    .tgt_bcd_hour_i (tgt_bcd_hour),
    .tgt_bcd_min_i  (tgt_bcd_min),
    .tgt_bcd_sec_i  (tgt_bcd_sec),
    .tgt_sb_year_i  (tgt_sb_year),
    .tgt_sb_day_i   (tgt_sb_day),
    .tgt_sb_sod_i   (tgt_sb_sod),
    .tgt_usec_i     (tgt_usec),
    .match_o        (match_w)
  );

  tod_edge_arm #(.SETUP_W(SETUP_W)) u_edge (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .match_i (match_w),
    .setup_i (setup_w),
    .trig_o  (trig_o)
  );

endmodule

// File: rtl/tod_match_trigger_chk.sv
module tod_match_trigger_chk #(
  parameter int unsigned SRC_W   = 4,
  parameter int unsigned SETUP_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SRC_W-1:0]   src_code,
  input logic [5:0]         fld_mask,
  input logic               match_w,
  input logic [SETUP_W-1:0] setup_w,
  input logic               trig_o
);

  logic is_bcd, is_sb;
  assign is_bcd = (src_code == SRC_W'(2));
  assign is_sb  = (src_code == SRC_W'(3));

  AST_OFF_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_bcd && !is_sb) |=> !trig_o); // R3

  AST_BCD_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bcd && (&fld_mask[4:0])) |=> !trig_o); // R6

  AST_SB_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sb && fld_mask[5] && fld_mask[4] && fld_mask[1] && fld_mask[0]) |=> !trig_o); // R6

  AST_TRIG_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(match_w)); // R7

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && $stable(setup_w)) |=> !trig_o); // R8

endmodule

bind tod_match_trigger tod_match_trigger_chk #(
  .SRC_W   (SRC_W),
  .SETUP_W (SETUP_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_code (src_code),
  .fld_mask (fld_mask),
  .match_w  (match_w),
  .setup_w  (setup_w),
  .trig_o   (trig_o)
);

// File: tb/tod_match_trigger_tb.sv
module tod_match_trigger_tb;

  logic        clk;
  logic        rst_n;
  logic [3:0]  src_code;
  logic [5:0]  fld_mask;
  logic [11:0] cur_bcd_day, tgt_bcd_day;
  logic [7:0]  cur_bcd_hour, tgt_bcd_hour;
  logic [7:0]  cur_bcd_min, tgt_bcd_min;
  logic [7:0]  cur_bcd_sec, tgt_bcd_sec;
  logic [11:0] cur_sb_year, tgt_sb_year;
  logic [8:0]  cur_sb_day, tgt_sb_day;
  logic [16:0] cur_sb_sod, tgt_sb_sod;
  logic [19:0] cur_usec, tgt_usec;
  logic        trig_o;

  int n_chk;
  int n_bad;

  tod_match_trigger u_dut (
    .clk (clk), .rst_n (rst_n), .src_code (src_code), .fld_mask (fld_mask),
    .cur_bcd_day (cur_bcd_day), .cur_bcd_hour (cur_bcd_hour),
    .cur_bcd_min (cur_bcd_min), .cur_bcd_sec (cur_bcd_sec),
    .cur_sb_year (cur_sb_year), .cur_sb_day (cur_sb_day),
    .cur_sb_sod (cur_sb_sod), .cur_usec (cur_usec),
    .tgt_bcd_day (tgt_bcd_day), .tgt_bcd_hour (tgt_bcd_hour),
    .tgt_bcd_min (tgt_bcd_min), .tgt_bcd_sec (tgt_bcd_sec),
    .tgt_sb_year (tgt_sb_year), .tgt_sb_day (tgt_sb_day),
    .tgt_sb_sod (tgt_sb_sod), .tgt_usec (tgt_usec),
    .trig_o (trig_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // diff: 0 bcd day, 1 hour, 2 min, 3 sec, 4 year, 5 bin day, 6 sod, 7 usec, 8 none
  typedef struct packed {
    logic [3:0] src;
    logic [5:0] mask;
    logic [3:0] diff;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 6'h00, 4'd8, 1'b1, 4'd1},  // R1 full BCD match
    '{4'd3, 6'h00, 4'd8, 1'b1, 4'd2},  // R2 full binary match
    '{4'd2, 6'h00, 4'd1, 1'b0, 4'd1},  // R1 hour differs
    '{4'd2, 6'h08, 4'd1, 1'b1, 4'd4},  // R4 hour masked
    '{4'd2, 6'h00, 4'd4, 1'b1, 4'd5},  // R5 year ignored in BCD
    '{4'd3, 6'h00, 4'd4, 1'b0, 4'd2},  // R2 year differs
    '{4'd3, 6'h20, 4'd4, 1'b1, 4'd4},  // R4 year masked
    '{4'd3, 6'h00, 4'd1, 1'b1, 4'd5},  // R5 BCD hour ignored in binary
    '{4'd3, 6'h00, 4'd6, 1'b0, 4'd2},  // R2 sod differs
    '{4'd3, 6'h02, 4'd6, 1'b1, 4'd5},  // R5 sod under bit 1
    '{4'd2, 6'h00, 4'd7, 1'b0, 4'd1},  // R1 usec differs
    '{4'd2, 6'h01, 4'd7, 1'b1, 4'd4},  // R4 usec masked
    '{4'd5, 6'h00, 4'd8, 1'b0, 4'd3},  // R3 unknown code
    '{4'd0, 6'h00, 4'd8, 1'b0, 4'd3},  // R3 code zero
    '{4'd2, 6'h1F, 4'd8, 1'b0, 4'd6},  // R6 all BCD fields masked
    '{4'd3, 6'h33, 4'd8, 1'b0, 4'd6},  // R6 all binary fields masked
    '{4'd3, 6'h1C, 4'd8, 1'b1, 4'd4},  // R4 partial mask, binary
    '{4'd2, 6'h20, 4'd8, 1'b1, 4'd5},  // R5 year mask ignored in BCD
    '{4'd3, 6'h0C, 4'd6, 1'b0, 4'd5}   // R5 hour/min mask do not hide sod
  };

  task automatic check(input logic act, input logic exp, input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] src, input logic [5:0] mask, input int diff);
    src_code = src;
    fld_mask = mask;
    tgt_bcd_day = 12'h123; tgt_bcd_hour = 8'h14; tgt_bcd_min = 8'h35; tgt_bcd_sec = 8'h52;
    tgt_sb_year = 12'd2024; tgt_sb_day = 9'd123; tgt_sb_sod = 17'd52552; tgt_usec = 20'd654321;
    cur_bcd_day = tgt_bcd_day; cur_bcd_hour = tgt_bcd_hour; cur_bcd_min = tgt_bcd_min;
    cur_bcd_sec = tgt_bcd_sec; cur_sb_year = tgt_sb_year; cur_sb_day = tgt_sb_day;
    cur_sb_sod = tgt_sb_sod; cur_usec = tgt_usec;
    case (diff)
      0: cur_bcd_day  = 12'h124;
      1: cur_bcd_hour = 8'h15;
      2: cur_bcd_min  = 8'h36;
      3: cur_bcd_sec  = 8'h53;
      4: cur_sb_year  = 12'd2025;
      5: cur_sb_day   = 9'd124;
      6: cur_sb_sod   = 17'd52553;
      7: cur_usec     = 20'd654322;
      default: ;
    endcase
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    apply(4'd0, 6'h00, 8);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pulses;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    apply(4'd2, 6'h00, 8);
    // R10: quiet under reset despite matching inputs
    for (int i = 0; i < 3; i++) begin
      tick();
      check(trig_o, 1'b0, 10, "low during reset");
    end
    rst_n = 1'b1;
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (trig_o) pulses++;
    end
    check(pulses == 1, 1'b1, 10, "one pulse after reset release"); // R10

    // table walk
    for (int v = 0; v < NV; v++) begin
      idle(2);
      apply(VECS[v].src, VECS[v].mask, int'(VECS[v].diff));
      tick();
      check(trig_o, VECS[v].exp, int'(VECS[v].req), $sformatf("vector %0d", v));
    end

    // R7 latency: not before the edge, on it after
    idle(2);
    apply(4'd2, 6'h00, 8);
    #1;
    check(trig_o, 1'b0, 7, "no pulse before edge");
    tick();
    check(trig_o, 1'b1, 7, "pulse one edge later");
    // R8 persistence
    for (int i = 0; i < 3; i++) begin
      tick();
      check(trig_o, 1'b0, 8, "no repeat while matching");
    end
    // R7 fall and rise again
    cur_usec = 20'd1;
    tick();
    check(trig_o, 1'b0, 7, "mismatch cycle");
    cur_usec = tgt_usec;
    tick();
    check(trig_o, 1'b1, 7, "fires on new rise");
    tick();
    check(trig_o, 1'b0, 7, "single cycle");
    // R9 target change while matching
    tgt_usec = 20'd777;
    cur_usec = 20'd777;
    tick();
    check(trig_o, 1'b1, 9, "target change rearms");
    tick();
    check(trig_o, 1'b0, 9, "quiet after rearm pulse");
    fld_mask = 6'h04;
    tick();
    check(trig_o, 1'b1, 9, "mask change rearms");
    tick();
    check(trig_o, 1'b0, 8, "steady after mask change");
    tgt_usec = 20'd778;
    tick();
    check(trig_o, 1'b0, 9, "change to non-matching target");
    src_code = 4'd3;
    cur_usec = 20'd778;
    tick();
    check(trig_o, 1'b1, 9, "code change with match");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule